// File: doc/BRIEF.md
# Programmable Sum-of-Products Array with Output Inversion

This block is a small field-configurable logic array. Three primary inputs feed four product terms. Each product term is an AND of literals, and both the literal connections and the selection of products per output can be changed. Two outputs each form the OR of the product terms routed to them. Any product term may be routed to both outputs, so the outputs draw on one shared pool of products. A per-output inversion bit, applied through an XOR stage, lets an output be built from its complement when the complement needs fewer products.

Configuration is stored in flip-flops and written one row per clock edge through an addressed port. A plane-select bit chooses between an AND-plane row (one product term) and an output row (routing fuses plus inversion bit). The stored row at the current address can be read back at any time. There is no register between the primary inputs and the outputs.

A fuse bit of 1 means the connection is intact and present. A fuse bit of 0 means it is blown and absent. Input index 2 is named A, index 1 is B and index 0 is C.

Top module: `pla_core`

## Requirements
- R1: After reset every fuse bit is 1 and both inversion bits are 0. Readback gives 6'b111111 for each AND row and 6'b001111 for each output row, and both outputs are 0 for every input value.
- R2: With cfg_we=1 and cfg_sel=0, cfg_data[5:0] is stored as AND row cfg_addr at the next rising clock edge. Readback of that row returns the stored value.
- R3: With cfg_we=1 and cfg_sel=1, cfg_data[3:0] is stored as the routing fuses of output cfg_addr (bit p routes product p) and cfg_data[4] as its inversion bit. cfg_data[5] is not stored and reads back as 0.
- R4: In AND row p, bit 2i connects the true literal of input i and bit 2i+1 connects its complement. Product p is the AND of all connected literals.
- R5: A product with both fuses of any one input intact is 0 for every input value.
- R6: A product with all six fuses blown is constant 1.
- R7: Each output's sum is the OR of the products whose routing bit is set. One product may feed both outputs.
- R8: An output with its inversion bit set delivers the complement of its sum.
- R9: An output-row write to address 2 or 3 changes nothing, and output-row readback at those addresses is 0.
- R10: With cfg_we=0 no stored bit changes, whatever cfg_sel, cfg_addr and cfg_data hold.
- R11: The outputs follow a change of the primary inputs within the same cycle, with no clock edge needed.
- R12: The array can realise F1 = A·B' + A·C + A'·B·C' and F2 = (A·C + B·C)' together, with A·C shared between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset to the all-intact state |
| pla_in | input | 3 | Primary inputs, bit 2 = A, bit 1 = B, bit 0 = C |
| pla_out | output | 2 | Array outputs after the inversion stage |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | 0 selects an AND row, 1 selects an output row |
| cfg_addr | input | 2 | Row index for write and readback |
| cfg_data | input | 6 | Row value to write |
| cfg_rdata | output | 6 | Stored row at cfg_addr and cfg_sel, zero-padded |

## Verification
A wrong stored fuse appears in two places: on cfg_rdata in the cycle after the write edge, and at the outputs for the input combinations that the affected literal or routing bit decides. The bench therefore reads back every row and also sweeps all eight input values against an independent model. This makes a corrupted row visible at once rather than only under one input pattern. A fault in the conflict, empty-product or inversion logic needs no clock to appear: it shows on pla_out as soon as the inputs settle. The bench samples the outputs one time step after each input change.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic {
    PLANE_AND = 1'b0,
    PLANE_OR  = 1'b1
  } plane_e;

  // One literal slot: passes unless a connected literal is false.
  function automatic logic literal_pass(logic x, logic f_true, logic f_comp);
    return (~f_true | x) & (~f_comp | ~x);
  endfunction

  function automatic int max_int(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pla_fuse_store.sv
module pla_fuse_store
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_PROD = 4,
  parameter int N_OUT  = 2,
  parameter int AW     = 2,
  parameter int DW     = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic                           sel,
  input  logic [AW-1:0]                  addr,
  input  logic [DW-1:0]                  wdata,
  output logic [N_PROD-1:0][2*N_IN-1:0]  and_fuse,
  output logic [N_OUT-1:0][N_PROD-1:0]   or_fuse,
  output logic [N_OUT-1:0]               pol,
  output logic [DW-1:0]                  rdata
);
  localparam int AND_W = 2 * N_IN;

  logic [N_PROD-1:0] and_hit;
  logic [N_OUT-1:0]  or_hit;

  for (genvar p = 0; p < N_PROD; p++) begin : g_and_dec
    assign and_hit[p] = we && (sel == PLANE_AND) && (addr == AW'(p));
  end
  for (genvar o = 0; o < N_OUT; o++) begin : g_or_dec
    assign or_hit[o] = we && (sel == PLANE_OR) && (addr == AW'(o));
  end

  for (genvar p = 0; p < N_PROD; p++) begin : g_and_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          and_fuse[p] <= '1;
      else if (and_hit[p]) and_fuse[p] <= wdata[AND_W-1:0];
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_or_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        or_fuse[o] <= '1;
        pol[o]     <= 1'b0;
      end else if (or_hit[o]) begin
        or_fuse[o] <= wdata[N_PROD-1:0];
        pol[o]     <= wdata[N_PROD];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int p = 0; p < N_PROD; p++)
      if (sel == PLANE_AND && addr == AW'(p)) rdata = DW'(and_fuse[p]);
    for (int o = 0; o < N_OUT; o++)
      if (sel == PLANE_OR && addr == AW'(o)) rdata = DW'({pol[o], or_fuse[o]});
  end

  // Any write decode active at all
  logic any_hit;
  assign any_hit = (|and_hit) | (|or_hit);

  assert_and_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == PLANE_AND && addr == AW'(0)) |=> (and_fuse[0] == $past(wdata[AND_W-1:0])));

  assert_or_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == PLANE_OR && addr == AW'(0)) |=>
      ({pol[0], or_fuse[0]} == $past(wdata[N_PROD:0])));

  assert_no_write_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(and_fuse) && $stable(or_fuse) && $stable(pol)));

  assert_range_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == PLANE_OR && !any_hit) |=> ($stable(or_fuse) && $stable(pol) && $stable(and_fuse)));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_PROD = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_IN-1:0]               in_vec,
  input  logic [N_PROD-1:0][2*N_IN-1:0] and_fuse,
  output logic [N_PROD-1:0]             prod
);
  logic [N_PROD-1:0] conflict;
  logic [N_PROD-1:0] empty_row;

  for (genvar p = 0; p < N_PROD; p++) begin : g_prod
    logic [N_IN-1:0] lit_ok;
    logic [N_IN-1:0] both_in;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign lit_ok[i]  = literal_pass(in_vec[i], and_fuse[p][2*i], and_fuse[p][2*i+1]);
      assign both_in[i] = and_fuse[p][2*i] & and_fuse[p][2*i+1];
    end
    assign prod[p]      = &lit_ok;
    assign conflict[p]  = |both_in;
    assign empty_row[p] = ~|and_fuse[p];

    assert_conflict_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      conflict[p] |-> !prod[p]);
    assert_empty_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
      empty_row[p] |-> prod[p]);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_PROD = 4,
  parameter int N_OUT  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_PROD-1:0]           prod,
  input  logic [N_OUT-1:0][N_PROD-1:0] or_fuse,
  input  logic [N_OUT-1:0]            pol,
  output logic [N_OUT-1:0]            out_vec
);
  logic [N_OUT-1:0] or_sum;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign or_sum[o]  = |(prod & or_fuse[o]);
    assign out_vec[o] = or_sum[o] ^ pol[o];

    assert_inv_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pol[o] && ((prod & or_fuse[o]) == '0)) |-> out_vec[o]);
    assert_sum_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(prod) && $stable(or_fuse[o]) && $stable(pol[o])) |-> $stable(out_vec[o]));
  end

endmodule

// File: rtl/pla_core.sv
module pla_core
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_PROD = 4,
  parameter int N_OUT  = 2,
  localparam int AW    = $clog2(max_int(max_int(N_PROD, N_OUT), 2)),
  localparam int DW    = max_int(2 * N_IN, N_PROD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   pla_in,
  output logic [N_OUT-1:0]  pla_out,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DW-1:0]     cfg_data,
  output logic [DW-1:0]     cfg_rdata
);
  logic [N_PROD-1:0][2*N_IN-1:0] and_fuse;
  logic [N_OUT-1:0][N_PROD-1:0]  or_fuse;
  logic [N_OUT-1:0]              pol;
  logic [N_PROD-1:0]             prod;

  pla_fuse_store #(
    .N_IN(N_IN), .N_PROD(N_PROD), .N_OUT(N_OUT), .AW(AW), .DW(DW)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .addr(cfg_addr),
    .wdata(cfg_data), .and_fuse(and_fuse), .or_fuse(or_fuse), .pol(pol),
    .rdata(cfg_rdata)
  );

  pla_and_plane #(.N_IN(N_IN), .N_PROD(N_PROD)) u_and (
    .clk(clk), .rst_n(rst_n), .in_vec(pla_in), .and_fuse(and_fuse), .prod(prod)
  );

  pla_or_plane #(.N_PROD(N_PROD), .N_OUT(N_OUT)) u_or (
    .clk(clk), .rst_n(rst_n), .prod(prod), .or_fuse(or_fuse), .pol(pol),
    .out_vec(pla_out)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && !$past(cfg_we)) |-> (pla_out == '0));

endmodule

// File: tb/tb_pla_core.sv
module tb_pla_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pla_in = '0;
  logic [1:0] pla_out;
  logic       cfg_we = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [5:0] cfg_data = '0;
  logic [5:0] cfg_rdata;

  int checks = 0;
  int errors = 0;

  logic [5:0] m_and [4];
  logic [3:0] m_or  [2];
  logic       m_pol [2];

  always #2 clk = ~clk;

  pla_core dut (
    .clk(clk), .rst_n(rst_n), .pla_in(pla_in), .pla_out(pla_out),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_rdata(cfg_rdata)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent model: product true when no connected literal is false.
  function automatic logic [1:0] model(logic [2:0] x);
    logic [3:0] pr;
    logic [1:0] r;
    for (int p = 0; p < 4; p++) begin
      pr[p] = 1'b1;
      for (int i = 0; i < 3; i++) begin
        if (m_and[p][2*i] && !x[i])   pr[p] = 1'b0;
        if (m_and[p][2*i+1] && x[i])  pr[p] = 1'b0;
      end
    end
    for (int o = 0; o < 2; o++) r[o] = ((pr & m_or[o]) != 0) ^ m_pol[o];
    return r;
  endfunction

  task automatic model_reset();
    for (int p = 0; p < 4; p++) m_and[p] = 6'h3f;
    for (int o = 0; o < 2; o++) begin m_or[o] = 4'hf; m_pol[o] = 1'b0; end
  endtask

  task automatic cfg_write(logic sel, logic [1:0] a, logic [5:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!sel) m_and[a] = d;
    else if (a < 2) begin m_or[a] = d[3:0]; m_pol[a] = d[4]; end
  endtask

  task automatic read_row(string tag, logic sel, logic [1:0] a, logic [5:0] exp);
    cfg_sel = sel; cfg_addr = a;
    #1;
    check(tag, {2'b0, cfg_rdata}, {2'b0, exp});
  endtask

  task automatic sweep(string tag);
    for (int v = 0; v < 8; v++) begin
      pla_in = 3'(v);
      #1;
      check(tag, {6'b0, pla_out}, {6'b0, model(3'(v))});
    end
  endtask

  task automatic t_reset();
    for (int p = 0; p < 4; p++) read_row("R1 and row", 1'b0, 2'(p), 6'h3f);
    for (int o = 0; o < 2; o++) read_row("R1 out row", 1'b1, 2'(o), 6'h0f);
    for (int v = 0; v < 8; v++) begin
      pla_in = 3'(v); #1;
      check("R1 outputs zero", {6'b0, pla_out}, 8'h00);
    end
  endtask

  task automatic t_write_readback();
    cfg_write(1'b0, 2'd2, 6'b101010);
    read_row("R2 and readback", 1'b0, 2'd2, 6'b101010);
    cfg_write(1'b1, 2'd1, 6'b110101);
    read_row("R3 out readback bit5 dropped", 1'b1, 2'd1, 6'b010101);
  endtask

  task automatic t_literals();
    model_reset();
    cfg_write(1'b0, 2'd0, 6'b010000);  // A true
    cfg_write(1'b0, 2'd1, 6'b000010);  // C complement
    cfg_write(1'b0, 2'd2, 6'b000111);  // B true, C both: conflict
    cfg_write(1'b0, 2'd3, 6'b000000);  // empty row
    cfg_write(1'b1, 2'd0, 6'b000011);  // out0 = A + C'
    cfg_write(1'b1, 2'd1, 6'b000100);  // out1 = conflict product
    sweep("R4 literal product");
    for (int v = 0; v < 8; v++) begin
      pla_in = 3'(v); #1;
      check("R5 conflict product zero", {7'b0, pla_out[1]}, 8'h00);
    end
    cfg_write(1'b1, 2'd1, 6'b001000);  // out1 = empty product
    for (int v = 0; v < 8; v++) begin
      pla_in = 3'(v); #1;
      check("R6 empty product one", {7'b0, pla_out[1]}, 8'h01);
    end
  endtask

  task automatic t_share_polarity();
    cfg_write(1'b1, 2'd0, 6'b000001);
    cfg_write(1'b1, 2'd1, 6'b010001);
    sweep("R7 shared product");
    sweep("R8 inversion");
    pla_in = 3'b100; #1;
    check("R8 inverted out1", {7'b0, pla_out[1]}, 8'h00);
  endtask

  task automatic t_out_of_range();
    cfg_write(1'b1, 2'd2, 6'b011111);
    cfg_write(1'b1, 2'd3, 6'b000000);
    read_row("R9 addr2 reads zero", 1'b1, 2'd2, 6'h00);
    read_row("R9 addr3 reads zero", 1'b1, 2'd3, 6'h00);
    read_row("R9 out0 kept", 1'b1, 2'd0, {1'b0, m_pol[0], m_or[0]});
    read_row("R9 out1 kept", 1'b1, 2'd1, {1'b0, m_pol[1], m_or[1]});
    sweep("R9 outputs unchanged");
  endtask

  task automatic t_we_low();
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 1'b0; cfg_addr = 2'd0; cfg_data = 6'b111111;
    @(negedge clk); @(negedge clk);
    read_row("R10 and row kept", 1'b0, 2'd0, m_and[0]);
    cfg_data = 6'b000000;
    cfg_sel = 1'b1; cfg_addr = 2'd1;
    @(negedge clk); @(negedge clk);
    read_row("R10 out row kept", 1'b1, 2'd1, {1'b0, m_pol[1], m_or[1]});
  endtask

  task automatic t_comb_path();
    @(negedge clk);
    pla_in = 3'b000; #1;
    check("R11 comb a", {6'b0, pla_out}, {6'b0, model(3'b000)});
    pla_in = 3'b101; #1;
    check("R11 comb b", {6'b0, pla_out}, {6'b0, model(3'b101)});
  endtask

  task automatic t_f1f2();
    logic a, b, c;
    logic [1:0] exp;
    cfg_write(1'b0, 2'd0, 6'b011000);  // A B'
    cfg_write(1'b0, 2'd1, 6'b010001);  // A C
    cfg_write(1'b0, 2'd2, 6'b100110);  // A' B C'
    cfg_write(1'b0, 2'd3, 6'b000101);  // B C
    cfg_write(1'b1, 2'd0, 6'b000111);
    cfg_write(1'b1, 2'd1, 6'b011010);
    for (int v = 0; v < 8; v++) begin
      {a, b, c} = 3'(v);
      exp[0] = (a & ~b) | (a & c) | (~a & b & ~c);
      exp[1] = ~((a & c) | (b & c));
      pla_in = 3'(v); #1;
      check("R12 F1 F2", {6'b0, pla_out}, {6'b0, exp});
    end
  endtask

  initial begin
    model_reset();
    #10;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_readback();
    t_literals();
    t_share_polarity();
    t_out_of_range();
    t_we_low();
    t_comb_path();
    t_f1f2();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule